// File: doc/BRIEF.md
# Card Clock Generator with Start-Bit Update

This block derives the clock that drives a memory card from the controller's source clock. Software-facing configuration (divider value, source selection, enable, low-power) arrives on staged inputs. It does not reach the generator until an update request is issued. The request raises a start bit. The bit drops in the cycle the staged values are copied into the applied configuration. A request can be marked to wait until the data path is idle, so a transfer in progress is never disturbed.

An applied divider of zero passes the source clock straight through. A non-zero value N gives a card clock period of 2N source cycles with a 50 % duty cycle. The applied configuration only changes while the card clock sits at the end of a low phase, so a change of divider, mode or enable never produces a short pulse. When low-power is applied and neither a command nor a data transfer is active, the clock parks low at the end of a whole period. It resumes on the first source edge after activity is signalled.

A driver disables the clock and updates, then programs the divider and updates, then enables and updates again. The staged inputs can be held in ordinary registers elsewhere.

Top module: `cclk_gen`

## Requirements
- R1: After synchronous reset, start_o is 0, the applied divider, source, enable and low-power outputs are all 0, and cclk_o stays low.
- R2: Changing the staged inputs without an update request leaves the applied outputs and cclk_o unchanged.
- R3: An update request (upd_i high for one cycle) makes start_o read 1 after the next rising source edge. start_o returns to 0 in the cycle the applied outputs take the staged values present at that edge.
- R4: With enable 1 and applied divider N > 0, cclk_o has a period of 2N source cycles and is high for N of them.
- R5: With enable 1 and applied divider 0, cclk_o is high during each high phase of the source clock and low otherwise.
- R6: If upd_wait_i was 1 with the request, the update is held (start_o stays 1, applied values unchanged) for as long as data_busy_i is 1. If upd_wait_i was 0, data_busy_i does not hold it.
- R7: Every high pulse of cclk_o lasts exactly the half period of either the configuration before an update or the one after it. No low phase is shorter than the smaller of the two.
- R8: With applied enable 0, cclk_o stays low.
- R9: With low-power applied and both cmd_busy_i and data_busy_i low, cclk_o stops low after completing its period. When either busy input rises, cclk_o goes high at the next rising source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_div_i | input | DIV_W | Staged divider value (0 = pass-through) |
| stg_src_i | input | SRC_W | Staged clock source selection |
| stg_en_i | input | 1 | Staged card clock enable |
| stg_lp_i | input | 1 | Staged low-power (stop when idle) |
| upd_i | input | 1 | Update request pulse; sets the start bit |
| upd_wait_i | input | 1 | Defer the update while data is busy |
| cmd_busy_i | input | 1 | A command is in progress |
| data_busy_i | input | 1 | A data transfer is in progress |
| cclk_o | output | 1 | Card clock |
| start_o | output | 1 | Start bit, clears when the update is applied |
| cur_div_o | output | DIV_W | Applied divider value |
| cur_src_o | output | SRC_W | Applied source selection |
| cur_en_o | output | 1 | Applied enable |
| cur_lp_o | output | 1 | Applied low-power |

## Verification
The bench goes after the moments when the configuration changes. These include a divider change while the clock runs, a switch between pass-through and divided modes, and a disable and re-enable. Each of these edges is watched for a high pulse that fits neither the old nor the new half period, which a design applying settings mid-phase would produce as a runt. A deferred update under data activity is checked to stay pending. A design ignoring the wait flag would swap the divider during the transfer, and one applying the flag always would stall the unflagged update. Low-power parking is checked for a truly stopped clock and for a restart on the very next source edge. A design that restarted through the counter would lose several cycles.

// File: rtl/cclk_pkg.sv
package cclk_pkg;

  // Operating mode of the generator, decoded from the applied configuration.
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_DIV = 2'd1,
    MODE_BYP = 2'd2
  } clk_mode_e;

endpackage

// File: rtl/cclk_upd_ctrl.sv
module cclk_upd_ctrl
  import cclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] stg_div_i,
  input  logic [SRC_W-1:0] stg_src_i,
  input  logic             stg_en_i,
  input  logic             stg_lp_i,
  input  logic             upd_i,
  input  logic             upd_wait_i,
  input  logic             data_busy_i,
  input  logic             at_start_i,
  output logic             apply_o,
  output logic             pend_o,
  output logic [DIV_W-1:0] cur_div_o,
  output logic [SRC_W-1:0] cur_src_o,
  output logic             cur_en_o,
  output logic             cur_lp_o,
  output clk_mode_e        mode_o
);

  logic             pend_q;
  logic             wait_q;
  logic [DIV_W-1:0] div_q;
  logic [SRC_W-1:0] src_q;
  logic             en_q;
  logic             lp_q;
  logic             hold;

  // A flagged request is held off by data activity; every request waits for
  // the generator to sit at the end of a low phase.
  assign hold    = wait_q && data_busy_i;
  assign apply_o = pend_q && !hold && at_start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      div_q  <= '0;
      src_q  <= '0;
      en_q   <= 1'b0;
      lp_q   <= 1'b0;
    end else if (apply_o) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      div_q  <= stg_div_i;
      src_q  <= stg_src_i;
      en_q   <= stg_en_i;
      lp_q   <= stg_lp_i;
    end else if (upd_i && !pend_q) begin
      pend_q <= 1'b1;
      wait_q <= upd_wait_i;
    end
  end

  always_comb begin
    if (!en_q)               mode_o = MODE_OFF;
    else if (div_q == '0)    mode_o = MODE_BYP;
    else                     mode_o = MODE_DIV;
  end

  assign pend_o    = pend_q;
  assign cur_div_o = div_q;
  assign cur_src_o = src_q;
  assign cur_en_o  = en_q;
  assign cur_lp_o  = lp_q;

  AST_APPLY_TAKES_STAGED: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> (div_q == $past(stg_div_i) && en_q == $past(stg_en_i))); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$fell(pend_q) |-> ($stable(div_q) && $stable(en_q) && $stable(lp_q))); // R2
  AST_WAIT_DEFER: assert property (@(posedge clk) disable iff (rst)
    (pend_q && wait_q && data_busy_i) |=> pend_q); // R6
  AST_APPLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(at_start_i)); // R7

endmodule

// File: rtl/cclk_divider.sv
module cclk_divider
  import cclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             apply_i,
  input  logic             run_i,
  input  clk_mode_e        mode_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             div_o,
  output logic             at_start_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload;
  logic             ph_q;
  logic             go;

  assign reload = div_i - ONE;
  assign go     = run_i && (mode_i == MODE_DIV);

  // Down-counter per half period. The decision to start a high phase is
  // only taken at the start point, so phases always complete in full.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (apply_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (ph_q) begin
      if (cnt_q == '0) begin
        ph_q  <= 1'b0;
        cnt_q <= reload;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end else if (go) begin
      ph_q  <= 1'b1;
      cnt_q <= reload;
    end
  end

  assign div_o      = ph_q;
  assign at_start_o = !ph_q && (cnt_q == '0);

  AST_HIGH_ONLY_DIVIDED: assert property (@(posedge clk) disable iff (rst)
    ph_q |-> (mode_i == MODE_DIV)); // R4

endmodule

// File: rtl/cclk_gate.sv
module cclk_gate (
  input  logic clk,
  input  logic rst,
  input  logic byp_en_i,
  input  logic div_i,
  output logic cclk_o
);

  logic byp_q;

  // Enable for the pass-through path changes only while the source is low.
  always_ff @(negedge clk) begin
    if (rst) byp_q <= 1'b0;
    else     byp_q <= byp_en_i;
  end

  assign cclk_o = (clk & byp_q) | div_i;

  AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    byp_q |-> !div_i); // R5

endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
  import cclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] stg_div_i,
  input  logic [SRC_W-1:0] stg_src_i,
  input  logic             stg_en_i,
  input  logic             stg_lp_i,
  input  logic             upd_i,
  input  logic             upd_wait_i,
  input  logic             cmd_busy_i,
  input  logic             data_busy_i,
  output logic             cclk_o,
  output logic             start_o,
  output logic [DIV_W-1:0] cur_div_o,
  output logic [SRC_W-1:0] cur_src_o,
  output logic             cur_en_o,
  output logic             cur_lp_o
);

  clk_mode_e mode;
  logic      apply;
  logic      at_start;
  logic      run;
  logic      idle;
  logic      div_ph;

  cclk_upd_ctrl #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .stg_div_i  (stg_div_i),
    .stg_src_i  (stg_src_i),
    .stg_en_i   (stg_en_i),
    .stg_lp_i   (stg_lp_i),
    .upd_i      (upd_i),
    .upd_wait_i (upd_wait_i),
    .data_busy_i(data_busy_i),
    .at_start_i (at_start),
    .apply_o    (apply),
    .pend_o     (start_o),
    .cur_div_o  (cur_div_o),
    .cur_src_o  (cur_src_o),
    .cur_en_o   (cur_en_o),
    .cur_lp_o   (cur_lp_o),
    .mode_o     (mode)
  );

  assign idle = !cmd_busy_i && !data_busy_i;
  assign run  = cur_en_o && !(cur_lp_o && idle);

  cclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .apply_i   (apply),
    .run_i     (run),
    .mode_i    (mode),
    .div_i     (cur_div_o),
    .div_o     (div_ph),
    .at_start_o(at_start)
  );

  cclk_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .byp_en_i(run && (mode == MODE_BYP)),
    .div_i   (div_ph),
    .cclk_o  (cclk_o)
  );

  AST_OFF_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!cur_en_o && $past(!cur_en_o)) |-> !div_ph); // R8

endmodule

// File: tb/cclk_gen_tb_top.sv
module cclk_gen_tb_top;

  localparam int DIV_W = 8;
  localparam int SRC_W = 2;
  localparam longint HALF = 5; // 100 MHz source: 10 ns period

  typedef struct {
    string  tag;
    longint per;
    longint hi;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] stg_div_i = '0;
  logic [SRC_W-1:0] stg_src_i = '0;
  logic             stg_en_i = 1'b0;
  logic             stg_lp_i = 1'b0;
  logic             upd_i = 1'b0;
  logic             upd_wait_i = 1'b0;
  logic             cmd_busy_i = 1'b0;
  logic             data_busy_i = 1'b0;
  logic             cclk_o;
  logic             start_o;
  logic [DIV_W-1:0] cur_div_o;
  logic [SRC_W-1:0] cur_src_o;
  logic             cur_en_o;
  logic             cur_lp_o;

  int     total = 0;
  int     bad = 0;
  bit     done = 1'b0;
  item_t  sbq[$];
  int     skip = 0;
  longint last_rise = 0, prev_rise = 0, last_fall = 0;
  int     n_rise = 0;
  longint hi_a = 0, hi_b = 0, lo_min = 0;

  always #(HALF) clk = ~clk;

  cclk_gen #(.DIV_W(DIV_W), .SRC_W(SRC_W)) dut_i (
    .clk(clk), .rst(rst),
    .stg_div_i(stg_div_i), .stg_src_i(stg_src_i),
    .stg_en_i(stg_en_i), .stg_lp_i(stg_lp_i),
    .upd_i(upd_i), .upd_wait_i(upd_wait_i),
    .cmd_busy_i(cmd_busy_i), .data_busy_i(data_busy_i),
    .cclk_o(cclk_o), .start_o(start_o),
    .cur_div_o(cur_div_o), .cur_src_o(cur_src_o),
    .cur_en_o(cur_en_o), .cur_lp_o(cur_lp_o)
  );

  task automatic chk(string tag, longint act, longint exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: edge timing, glitch guard (R7) and scoreboard pops.
  always @(posedge cclk_o) begin
    longint lo;
    lo = $time - last_fall;
    if (!rst && last_fall != 0 && lo_min != 0) begin
      total++;
      if (lo < lo_min) begin
        bad++;
        $display("FAIL R7 short low actual=%0d expected>=%0d", lo, lo_min);
      end
    end
    prev_rise = last_rise;
    last_rise = $time;
    n_rise++;
  end

  always @(negedge cclk_o) begin
    longint hi, per;
    hi = $time - last_rise;
    per = last_rise - prev_rise;
    last_fall = $time;
    if (!rst && hi_a != 0) begin
      total++;
      if (hi != hi_a && hi != hi_b) begin
        bad++;
        $display("FAIL R7 runt high actual=%0d expected=%0d or %0d", hi, hi_a, hi_b);
      end
    end
    if (skip > 0) skip--;
    else if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      chk(it.tag, per, it.per, "period");
      chk(it.tag, hi, it.hi, "high time");
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_clk(string tag, longint per, longint hi, int n);
    skip = 2;
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.tag = tag; it.per = per; it.hi = hi;
      sbq.push_back(it);
    end
    for (int i = 0; i < 3000 && sbq.size() > 0; i++) tick();
    if (sbq.size() > 0) begin
      chk(tag, sbq.size(), 0, "items left unmatched");
      sbq.delete();
    end
  endtask

  task automatic do_update(string tag, int dv, int sr, bit en, bit lp, bit wt);
    stg_div_i = DIV_W'(dv); stg_src_i = SRC_W'(sr);
    stg_en_i = en; stg_lp_i = lp;
    upd_i = 1'b1; upd_wait_i = wt;
    tick();
    upd_i = 1'b0; upd_wait_i = 1'b0;
    chk("R3", start_o, 1, "start bit after request");
    for (int i = 0; i < 400 && start_o; i++) tick();
    chk("R3", start_o, 0, "start bit cleared");
    chk(tag, cur_div_o, dv, "applied divider");
    chk(tag, cur_en_o, en, "applied enable");
    chk(tag, cur_lp_o, lp, "applied low-power");
    chk(tag, cur_src_o, sr, "applied source");
  endtask

  initial begin
    int snap;
    repeat (5) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1", start_o, 0, "start after reset");
    chk("R1", cur_div_o, 0, "divider after reset");
    chk("R1", cur_en_o, 0, "enable after reset");
    chk("R1", cclk_o, 0, "cclk after reset");
    snap = n_rise;
    repeat (20) tick();
    chk("R1", n_rise - snap, 0, "rises after reset");

    // R2 staged values without request
    stg_div_i = 8'd5; stg_en_i = 1'b1; stg_lp_i = 1'b1; stg_src_i = 2'd3;
    snap = n_rise;
    repeat (12) tick();
    chk("R2", cur_en_o, 0, "enable without request");
    chk("R2", cur_div_o, 0, "divider without request");
    chk("R2", cur_lp_o, 0, "low-power without request");
    chk("R2", n_rise - snap, 0, "rises without request");

    // R4 divide by 2
    do_update("R4", 2, 1, 1, 0, 0);
    expect_clk("R4", 8 * HALF, 4 * HALF, 3);
    hi_a = 4 * HALF; hi_b = hi_a; lo_min = 4 * HALF;

    // R4/R7 divider change while running
    hi_b = 6 * HALF;
    do_update("R4", 3, 1, 1, 0, 0);
    expect_clk("R4", 12 * HALF, 6 * HALF, 3);
    hi_a = 6 * HALF; lo_min = 6 * HALF;

    // R6 deferred update under data activity
    data_busy_i = 1'b1;
    hi_b = 2 * HALF; lo_min = 2 * HALF;
    stg_div_i = 8'd1; upd_i = 1'b1; upd_wait_i = 1'b1;
    tick();
    upd_i = 1'b0; upd_wait_i = 1'b0;
    repeat (25) tick();
    chk("R6", start_o, 1, "start held while busy");
    chk("R6", cur_div_o, 3, "divider held while busy");
    data_busy_i = 1'b0;
    for (int i = 0; i < 400 && start_o; i++) tick();
    chk("R6", start_o, 0, "start after data idle");
    chk("R6", cur_div_o, 1, "divider after data idle");
    expect_clk("R4", 4 * HALF, 2 * HALF, 3);
    hi_a = 2 * HALF;

    // R6 unflagged update proceeds despite data activity
    data_busy_i = 1'b1;
    hi_b = 4 * HALF;
    do_update("R6", 2, 1, 1, 0, 0);
    data_busy_i = 1'b0;
    expect_clk("R4", 8 * HALF, 4 * HALF, 2);
    hi_a = 4 * HALF;

    // R5 pass-through
    hi_b = HALF; lo_min = HALF;
    do_update("R5", 0, 2, 1, 0, 0);
    expect_clk("R5", 2 * HALF, HALF, 4);
    hi_a = HALF;

    // R8 disable, program, enable
    do_update("R8", 0, 2, 0, 0, 0);
    repeat (3) tick();
    snap = n_rise;
    repeat (30) tick();
    chk("R8", n_rise - snap, 0, "rises while disabled");
    chk("R8", cclk_o, 0, "cclk while disabled");
    hi_b = 8 * HALF;
    do_update("R8", 4, 3, 0, 0, 0);
    snap = n_rise;
    repeat (20) tick();
    chk("R8", n_rise - snap, 0, "rises after divider set, disabled");
    do_update("R8", 4, 3, 1, 0, 0);
    expect_clk("R4", 16 * HALF, 8 * HALF, 2);
    hi_a = 8 * HALF;

    // R9 low-power parking and restart
    do_update("R9", 4, 3, 1, 1, 0);
    repeat (30) tick();
    snap = n_rise;
    repeat (40) tick();
    chk("R9", n_rise - snap, 0, "rises while idle");
    chk("R9", cclk_o, 0, "cclk parked level");
    cmd_busy_i = 1'b1;
    chk("R9", cclk_o, 0, "cclk before restart edge");
    tick();
    chk("R9", cclk_o, 1, "cclk one edge after busy");
    expect_clk("R9", 16 * HALF, 8 * HALF, 2);
    cmd_busy_i = 1'b0;
    repeat (30) tick();
    snap = n_rise;
    repeat (30) tick();
    chk("R9", n_rise - snap, 0, "rises after busy drops");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule